// File: doc/BRIEF.md
# Dual-Parallel Flash Bit Interleaver

This block connects a 32-bit word datapath to two identical quad-SPI flash devices. The devices run side by side on separate 4-bit buses, which gives eight data lines in total. Both devices receive the same opcode and the same address nibbles. Only the data phase is split, and it is split by bit parity. The even bits of each host byte go to the lower device and the odd bits go to the upper device. On a read the two nibble streams are merged back into one word.

How responses are merged depends on the command class. A status read forms bit 0 from the write-in-progress bits of both devices and takes the remaining bits from the lower device. An ID read keeps only the lower device's bytes. An erase or control command sends its opcode and address to both devices and has no data phase. For memory data accesses the 25-bit host byte address is halved, because every device byte holds half of a host byte pair. Such accesses must be word aligned.

The sequencer has six states:
- `ST_IDLE` goes to `ST_OPCODE` when `start` is accepted.
- `ST_OPCODE` goes to `ST_ADDR` for the data and erase classes, and to `ST_READ` for the status and ID classes.
- `ST_ADDR` goes to `ST_WRITE` for a data write, to `ST_READ` for a data read, and to `ST_DONE` for an erase.
- `ST_WRITE` goes to `ST_DONE`.
- `ST_READ` goes to `ST_DONE`.
- `ST_DONE` goes to `ST_IDLE`.

A misaligned data request keeps the sequencer in `ST_IDLE`.

Top module: `twin_flash_interleave`

## Requirements
- R1: After reset `busy`, `bus_oe`, `bus_capture`, `rdata_valid` and `align_err` are all 0.
- R2: Every accepted transaction starts with two `bus_oe` cycles that carry the opcode, high nibble first. The nibble is identical on `lo_dout` and `hi_dout`.
- R3: Classes 0 (data) and 3 (erase/control) then drive six address cycles, 24 bits, most significant nibble first, identical on both buses. Class 0 sends `host_addr[24:1]` and class 3 sends `host_addr[23:0]`. Classes 1 and 2 send no address.
- R4: A class 0 write then drives four cycles. In cycle k (0..3), bit j of `lo_dout` is `wdata[8k+2j]` and bit j of `hi_dout` is `wdata[8k+2j+1]`.
- R5: A class 0 read takes four `bus_capture` cycles. In capture k, `rdata[8k+2j]` takes `lo_din[j]` and `rdata[8k+2j+1]` takes `hi_din[j]`. As a result, a word written and then read back returns unchanged.
- R6: A class 1 (status) read takes two capture cycles and forms one byte from each bus, high nibble first. `rdata[0]` is the OR of bit 0 of the lower byte and bit 0 of the upper byte. `rdata[7:1]` comes from the lower byte, and `rdata[31:8]` is 0.
- R7: A class 2 (ID) read takes eight capture cycles from `lo_din` only. The nibbles form bytes high nibble first, and byte n lands in `rdata[8n+7:8n]`. `hi_din` has no effect.
- R8: A class 3 transaction has no data phase. `bus_capture` stays 0 and `rdata_valid` does not pulse.
- R9: A class 0 request with `host_addr[1:0]` not 0 is rejected. `align_err` is 1 for exactly the cycle after `start`, and `busy` and `bus_oe` stay 0.
- R10: `rdata_valid` is a single-cycle pulse in the cycle after the final capture. `busy` stays high from the cycle after `start` through that pulse, which is 13 cycles for a data read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Request a transaction (sampled in idle) |
| cmd_class | input | 2 | 0 data, 1 status, 2 ID, 3 erase/control |
| is_write | input | 1 | Data class: 1 write, 0 read |
| opcode | input | 8 | Command byte sent to both devices |
| host_addr | input | 25 | Host byte address |
| wdata | input | 32 | Word to split on a write |
| busy | output | 1 | Transaction in progress |
| align_err | output | 1 | Misaligned data request rejected |
| bus_oe | output | 1 | Controller drives both nibble buses |
| bus_capture | output | 1 | Controller samples both nibble buses |
| lo_dout | output | 4 | Nibble to lower (even-bit) device |
| hi_dout | output | 4 | Nibble to upper (odd-bit) device |
| lo_din | input | 4 | Nibble from lower device |
| hi_din | input | 4 | Nibble from upper device |
| rdata | output | 32 | Merged read result |
| rdata_valid | output | 1 | Read result valid pulse |

## Verification
The bench writes corner-case and random words and reads each one back through a two-device model. A swapped parity, a reversed nibble order or a wrong byte lane would return a changed word and show up as lane-specific nibble mismatches. It sweeps all four combinations of the two write-in-progress bits. A design that takes the bit from only one device, or that ANDs instead of ORs, would miss at least one combination. It repeats an ID read with different upper-bus data to catch any leakage of the upper bus. It also drives every misaligned low-address pattern, and it checks that the erase address is not halved while the data address is.

// File: rtl/twin_flash_pkg.sv
package twin_flash_pkg;
    typedef enum logic [1:0] {
        CLS_DATA   = 2'd0,
        CLS_STATUS = 2'd1,
        CLS_ID     = 2'd2,
        CLS_ERASE  = 2'd3
    } cmd_class_e;

    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_OPCODE = 3'd1,
        ST_ADDR   = 3'd2,
        ST_WRITE  = 3'd3,
        ST_READ   = 3'd4,
        ST_DONE   = 3'd5
    } phase_e;
endpackage

// File: rtl/twin_flash_hdr.sv
module twin_flash_hdr #(
    parameter int OPC_W  = 8,
    parameter int DEV_AW = 24,
    parameter int NIB_W  = 4,
    parameter int CNT_W  = 4
) (
    input  logic [OPC_W-1:0]  opcode,
    input  logic [DEV_AW-1:0] dev_addr,
    input  logic              sel_addr,
    input  logic [CNT_W-1:0]  idx,
    output logic [NIB_W-1:0]  nib
);
    localparam int OPC_CYC  = OPC_W / NIB_W;
    localparam int ADDR_CYC = DEV_AW / NIB_W;

    always_comb begin
        int sh;
        nib = '0;
        if (sel_addr) begin
            sh = (ADDR_CYC - 1 - int'(idx)) * NIB_W;
            if (sh >= 0 && sh <= DEV_AW - NIB_W) begin
                nib = dev_addr[sh +: NIB_W];
            end
        end else begin
            sh = (OPC_CYC - 1 - int'(idx)) * NIB_W;
            if (sh >= 0 && sh <= OPC_W - NIB_W) begin
                nib = opcode[sh +: NIB_W];
            end
        end
    end
endmodule

// File: rtl/twin_flash_split.sv
module twin_flash_split #(
    parameter int WORD_W = 32,
    parameter int NIB_W  = 4,
    parameter int CNT_W  = 4
) (
    input  logic [WORD_W-1:0] word,
    input  logic [CNT_W-1:0]  idx,
    output logic [NIB_W-1:0]  lo_nib,
    output logic [NIB_W-1:0]  hi_nib
);
    localparam int BYTE_W   = 2 * NIB_W;
    localparam int DATA_CYC = WORD_W / BYTE_W;

    logic [BYTE_W-1:0] byte_sel;

    always_comb begin
        byte_sel = '0;
        if (int'(idx) < DATA_CYC) begin
            byte_sel = word[int'(idx) * BYTE_W +: BYTE_W];
        end
    end

    for (genvar j = 0; j < NIB_W; j++) begin : g_lane
        assign lo_nib[j] = byte_sel[2*j];
        assign hi_nib[j] = byte_sel[2*j+1];
    end
endmodule

// File: rtl/twin_flash_gather.sv
module twin_flash_gather
    import twin_flash_pkg::*;
#(
    parameter int WORD_W = 32,
    parameter int NIB_W  = 4,
    parameter int CNT_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              cap_en,
    input  cmd_class_e        cls,
    input  logic [CNT_W-1:0]  idx,
    input  logic [NIB_W-1:0]  lo_din,
    input  logic [NIB_W-1:0]  hi_din,
    output logic [WORD_W-1:0] word
);
    localparam int BYTE_W   = 2 * NIB_W;
    localparam int DATA_CYC = WORD_W / BYTE_W;
    localparam int ID_CYC   = WORD_W / NIB_W;

    logic [WORD_W-1:0] word_q, word_d;

    always_comb begin
        int base;
        word_d = word_q;
        base   = 0;
        if (clr) begin
            word_d = '0;
        end else if (cap_en) begin
            unique case (cls)
                CLS_DATA: begin
                    base = int'(idx) * BYTE_W;
                    if (int'(idx) < DATA_CYC) begin
                        for (int j = 0; j < NIB_W; j++) begin
                            word_d[base + 2*j]     = lo_din[j];
                            word_d[base + 2*j + 1] = hi_din[j];
                        end
                    end
                end
                CLS_STATUS: begin
                    if (idx == '0) begin
                        word_d[NIB_W +: NIB_W] = lo_din;
                    end else begin
                        word_d[NIB_W-1:1] = lo_din[NIB_W-1:1];
                        word_d[0]         = lo_din[0] | hi_din[0];
                    end
                end
                CLS_ID: begin
                    base = (int'(idx) / 2) * BYTE_W + (idx[0] ? 0 : NIB_W);
                    if (int'(idx) < ID_CYC) begin
                        word_d[base +: NIB_W] = lo_din;
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) word_q <= '0;
        else        word_q <= word_d;
    end

    assign word = word_q;

    AST_ID_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (cap_en && cls == CLS_ID) |-> int'(idx) < ID_CYC); // R7
    AST_DATA_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (cap_en && cls == CLS_DATA) |-> int'(idx) < DATA_CYC); // R5
endmodule

// File: rtl/twin_flash_interleave.sv
module twin_flash_interleave
    import twin_flash_pkg::*;
#(
    parameter int HOST_AW = 25,
    parameter int WORD_W  = 32,
    parameter int NIB_W   = 4,
    parameter int OPC_W   = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    input  logic [1:0]         cmd_class,
    input  logic               is_write,
    input  logic [OPC_W-1:0]   opcode,
    input  logic [HOST_AW-1:0] host_addr,
    input  logic [WORD_W-1:0]  wdata,
    output logic               busy,
    output logic               align_err,
    output logic               bus_oe,
    output logic               bus_capture,
    output logic [NIB_W-1:0]   lo_dout,
    output logic [NIB_W-1:0]   hi_dout,
    input  logic [NIB_W-1:0]   lo_din,
    input  logic [NIB_W-1:0]   hi_din,
    output logic [WORD_W-1:0]  rdata,
    output logic               rdata_valid
);
    localparam int DEV_AW   = HOST_AW - 1;
    localparam int BYTE_W   = 2 * NIB_W;
    localparam int OPC_CYC  = OPC_W / NIB_W;
    localparam int ADDR_CYC = DEV_AW / NIB_W;
    localparam int DATA_CYC = WORD_W / BYTE_W;
    localparam int STAT_CYC = BYTE_W / NIB_W;
    localparam int ID_CYC   = WORD_W / NIB_W;
    localparam int CNT_W    = $clog2(ID_CYC + 1);
    localparam int ALIGN_B  = $clog2(WORD_W / 8);

    phase_e            state_q, state_d;
    logic [CNT_W-1:0]  cnt_q, cnt_d, last_cnt;
    cmd_class_e        cls_q, cls_in;
    logic              wr_q;
    logic [OPC_W-1:0]  opc_q;
    logic [DEV_AW-1:0] addr_q;
    logic [WORD_W-1:0] wdat_q;
    logic              align_q;
    logic              misaligned, accept, reject, has_addr, read_txn;
    logic [NIB_W-1:0]  hdr_nib, spl_lo, spl_hi;

    assign cls_in     = cmd_class_e'(cmd_class);
    assign misaligned = (cls_in == CLS_DATA) && (host_addr[ALIGN_B-1:0] != '0);
    assign accept     = (state_q == ST_IDLE) && start && !misaligned;
    assign reject     = (state_q == ST_IDLE) && start && misaligned;
    assign has_addr   = (cls_q == CLS_DATA) || (cls_q == CLS_ERASE);
    assign read_txn   = (cls_q == CLS_STATUS) || (cls_q == CLS_ID) ||
                        ((cls_q == CLS_DATA) && !wr_q);

    always_comb begin
        unique case (state_q)
            ST_OPCODE: last_cnt = CNT_W'(OPC_CYC - 1);
            ST_ADDR:   last_cnt = CNT_W'(ADDR_CYC - 1);
            ST_WRITE:  last_cnt = CNT_W'(DATA_CYC - 1);
            ST_READ:   last_cnt = (cls_q == CLS_STATUS) ? CNT_W'(STAT_CYC - 1) :
                                  (cls_q == CLS_ID)     ? CNT_W'(ID_CYC - 1) :
                                                          CNT_W'(DATA_CYC - 1);
            default:   last_cnt = '0;
        endcase
    end

    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        unique case (state_q)
            ST_IDLE: begin
                if (accept) begin
                    state_d = ST_OPCODE;
                    cnt_d   = '0;
                end
            end
            ST_OPCODE: begin
                if (cnt_q == last_cnt) begin
                    cnt_d   = '0;
                    state_d = has_addr ? ST_ADDR : ST_READ;
                end else cnt_d = cnt_q + CNT_W'(1);
            end
            ST_ADDR: begin
                if (cnt_q == last_cnt) begin
                    cnt_d   = '0;
                    state_d = (cls_q == CLS_ERASE) ? ST_DONE :
                              (wr_q ? ST_WRITE : ST_READ);
                end else cnt_d = cnt_q + CNT_W'(1);
            end
            ST_WRITE, ST_READ: begin
                if (cnt_q == last_cnt) begin
                    cnt_d   = '0;
                    state_d = ST_DONE;
                end else cnt_d = cnt_q + CNT_W'(1);
            end
            ST_DONE: state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
            cls_q   <= CLS_DATA;
            wr_q    <= 1'b0;
            opc_q   <= '0;
            addr_q  <= '0;
            wdat_q  <= '0;
            align_q <= 1'b0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
            align_q <= reject;
            if (accept) begin
                cls_q  <= cls_in;
                wr_q   <= is_write;
                opc_q  <= opcode;
                addr_q <= (cls_in == CLS_DATA) ? host_addr[HOST_AW-1:1]
                                               : host_addr[DEV_AW-1:0];
                wdat_q <= wdata;
            end
        end
    end

    twin_flash_hdr #(
        .OPC_W(OPC_W), .DEV_AW(DEV_AW), .NIB_W(NIB_W), .CNT_W(CNT_W)
    ) u_hdr (
        .opcode(opc_q), .dev_addr(addr_q), .sel_addr(state_q == ST_ADDR),
        .idx(cnt_q), .nib(hdr_nib)
    );

    twin_flash_split #(
        .WORD_W(WORD_W), .NIB_W(NIB_W), .CNT_W(CNT_W)
    ) u_split (
        .word(wdat_q), .idx(cnt_q), .lo_nib(spl_lo), .hi_nib(spl_hi)
    );

    twin_flash_gather #(
        .WORD_W(WORD_W), .NIB_W(NIB_W), .CNT_W(CNT_W)
    ) u_gather (
        .clk(clk), .rst_n(rst_n), .clr(accept), .cap_en(state_q == ST_READ),
        .cls(cls_q), .idx(cnt_q), .lo_din(lo_din), .hi_din(hi_din), .word(rdata)
    );

    always_comb begin
        busy        = (state_q != ST_IDLE);
        align_err   = align_q;
        bus_oe      = 1'b0;
        bus_capture = 1'b0;
        rdata_valid = 1'b0;
        lo_dout     = '0;
        hi_dout     = '0;
        unique case (state_q)
            ST_OPCODE, ST_ADDR: begin
                bus_oe  = 1'b1;
                lo_dout = hdr_nib;
                hi_dout = hdr_nib;
            end
            ST_WRITE: begin
                bus_oe  = 1'b1;
                lo_dout = spl_lo;
                hi_dout = spl_hi;
            end
            ST_READ:  bus_capture = 1'b1;
            ST_DONE:  rdata_valid = read_txn;
            default: ;
        endcase
    end

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE) |-> (!bus_oe && !bus_capture && !rdata_valid)); // R1
    AST_HDR_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_OPCODE || state_q == ST_ADDR) |-> (lo_dout == hi_dout)); // R2
    AST_ADDR_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_ADDR && $past(state_q) != ST_ADDR) |-> $past(state_q) == ST_OPCODE); // R3
    AST_ERASE_NO_CAP: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && cls_q == CLS_ERASE) |-> (!bus_capture && !rdata_valid)); // R8
    AST_STATUS_UPPER: assert property (@(posedge clk) disable iff (!rst_n)
        (rdata_valid && cls_q == CLS_STATUS) |-> (rdata[WORD_W-1:BYTE_W] == '0)); // R6
    AST_ALIGN_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        align_err |-> (!busy && !bus_oe)); // R9
    AST_VALID_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        rdata_valid |=> !rdata_valid); // R10
    AST_VALID_AFTER_CAP: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rdata_valid) |-> $past(bus_capture)); // R10
endmodule

// File: tb/twin_flash_interleave_bench.sv
module twin_flash_interleave_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [1:0]  cmd_class = 2'd0;
    logic        is_write = 1'b0;
    logic [7:0]  opcode = 8'h00;
    logic [24:0] host_addr = '0;
    logic [31:0] wdata = '0;
    logic        busy, align_err, bus_oe, bus_capture, rdata_valid;
    logic [3:0]  lo_dout, hi_dout;
    logic [3:0]  lo_din = 4'h0, hi_din = 4'h0;
    logic [31:0] rdata;

    int checks = 0;
    int fails  = 0;

    logic [3:0]  out_lo [0:31];
    logic [3:0]  out_hi [0:31];
    logic [3:0]  rsp_lo [0:15];
    logic [3:0]  rsp_hi [0:15];
    int          n_oe, n_cap, n_valid, n_busy, n_align;
    logic [31:0] got_rdata;

    always #10 clk = ~clk;

    twin_flash_interleave u_twin_flash_interleave (
        .clk(clk), .rst_n(rst_n), .start(start), .cmd_class(cmd_class),
        .is_write(is_write), .opcode(opcode), .host_addr(host_addr), .wdata(wdata),
        .busy(busy), .align_err(align_err), .bus_oe(bus_oe), .bus_capture(bus_capture),
        .lo_dout(lo_dout), .hi_dout(hi_dout), .lo_din(lo_din), .hi_din(hi_din),
        .rdata(rdata), .rdata_valid(rdata_valid)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic run_txn(input logic [1:0] cls, input bit wr, input logic [7:0] opc,
                           input logic [24:0] addr, input logic [31:0] wd);
        @(negedge clk);
        cmd_class = cls; is_write = wr; opcode = opc; host_addr = addr; wdata = wd;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        n_oe = 0; n_cap = 0; n_valid = 0; n_busy = 0; n_align = 0; got_rdata = '0;
        for (int t = 0; t < 40; t++) begin
            if (align_err) n_align++;
            if (busy) n_busy++;
            if (bus_oe && n_oe < 32) begin
                out_lo[n_oe] = lo_dout; out_hi[n_oe] = hi_dout; n_oe++;
            end
            if (bus_capture) begin
                lo_din = rsp_lo[n_cap % 16]; hi_din = rsp_hi[n_cap % 16]; n_cap++;
            end else begin
                lo_din = 4'h0; hi_din = 4'h0;
            end
            if (rdata_valid) begin
                n_valid++; got_rdata = rdata;
            end
            if (!busy) break;
            @(negedge clk);
        end
    endtask

    function automatic bit header_ok(input logic [7:0] opc, input int n_addr, input logic [23:0] exp_addr);
        logic [23:0] a;
        bit ok;
        ok = (out_lo[0] == opc[7:4]) && (out_lo[1] == opc[3:0]);
        a  = '0;
        for (int i = 0; i < 2 + n_addr; i++) if (out_lo[i] != out_hi[i]) ok = 0;
        for (int i = 0; i < n_addr; i++) a = {a[19:0], out_lo[2+i]};
        if (n_addr != 0 && a != exp_addr) ok = 0;
        return ok;
    endfunction

    task automatic write_then_read(input logic [31:0] w, input logic [24:0] addr);
        bit ok;
        logic [7:0] op;
        op = 8'h38;
        run_txn(2'd0, 1'b1, op, addr, w);
        chk(n_oe == 12 && n_cap == 0 && n_valid == 0, "R4 write length", 32'(n_oe), 32'd12);
        chk(header_ok(op, 6, addr[24:1]), "R2 R3 write header/address halved",
            {8'h0, out_lo[2], out_lo[3], out_lo[4], out_lo[5], out_lo[6], out_lo[7]},
            {8'h0, addr[24:1]});
        ok = 1;
        for (int k = 0; k < 4; k++) begin
            for (int j = 0; j < 4; j++) begin
                if (out_lo[8+k][j] != w[8*k+2*j])   ok = 0;
                if (out_hi[8+k][j] != w[8*k+2*j+1]) ok = 0;
            end
            rsp_lo[k] = out_lo[8+k];
            rsp_hi[k] = out_hi[8+k];
        end
        chk(ok, "R4 parity split", {out_lo[8], out_hi[8], out_lo[9], out_hi[9],
            out_lo[10], out_hi[10], out_lo[11], out_hi[11]}, w);
        run_txn(2'd0, 1'b0, 8'h6B, addr, 32'h0);
        chk(n_oe == 8 && n_cap == 4, "R5 read phase lengths", 32'(n_cap), 32'd4);
        chk(n_valid == 1 && n_busy == 13, "R10 valid pulse / busy span", 32'(n_busy), 32'd13);
        chk(got_rdata == w, "R5 round trip", got_rdata, w);
    endtask

    initial begin
        #(20 * 200000);
        fails++;
        $display("FAIL watchdog expired actual=%0d expected=0", 1);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        logic [31:0] corner [0:4];
        logic [7:0]  lb, ub;
        logic [31:0] expw;
        logic [31:0] first_id;
        for (int i = 0; i < 16; i++) begin rsp_lo[i] = 4'h0; rsp_hi[i] = 4'h0; end
        repeat (3) @(negedge clk);
        chk(!busy && !bus_oe && !bus_capture && !rdata_valid && !align_err,
            "R1 reset outputs", {27'h0, busy, bus_oe, bus_capture, rdata_valid, align_err}, 32'h0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!busy && !bus_oe, "R1 idle after reset release", {30'h0, busy, bus_oe}, 32'h0);

        corner[0] = 32'h0000_0000; corner[1] = 32'hFFFF_FFFF; corner[2] = 32'hAAAA_AAAA;
        corner[3] = 32'h5555_5555; corner[4] = 32'h8000_0001;
        for (int i = 0; i < 5; i++) write_then_read(corner[i], 25'h1FF_FFFC);
        for (int i = 0; i < 40; i++) write_then_read($urandom, {$urandom} & 25'h1FF_FFFC);

        // R6: all four write-in-progress combinations
        for (int c = 0; c < 4; c++) begin
            lb = {7'($urandom), c[0]};
            ub = {7'($urandom), c[1]};
            rsp_lo[0] = lb[7:4]; rsp_lo[1] = lb[3:0];
            rsp_hi[0] = ub[7:4]; rsp_hi[1] = ub[3:0];
            run_txn(2'd1, 1'b0, 8'h05, 25'h0, 32'h0);
            expw = {24'h0, lb[7:1], lb[0] | ub[0]};
            chk(got_rdata == expw && n_valid == 1, "R6 status OR merge", got_rdata, expw);
            chk(n_oe == 2 && n_cap == 2 && header_ok(8'h05, 0, 24'h0),
                "R6 R2 status has no address", 32'(n_oe), 32'd2);
        end

        // R7: lower bus only, upper bus ignored
        for (int i = 0; i < 8; i++) begin rsp_lo[i] = 4'($urandom); rsp_hi[i] = 4'h0; end
        run_txn(2'd2, 1'b0, 8'h9F, 25'h0, 32'h0);
        expw = '0;
        for (int n = 0; n < 4; n++) expw[8*n +: 8] = {rsp_lo[2*n], rsp_lo[2*n+1]};
        chk(got_rdata == expw && n_cap == 8, "R7 ID bytes from lower bus", got_rdata, expw);
        first_id = got_rdata;
        for (int i = 0; i < 8; i++) rsp_hi[i] = 4'($urandom) | 4'h1;
        run_txn(2'd2, 1'b0, 8'h9F, 25'h0, 32'h0);
        chk(got_rdata == first_id, "R7 upper bus has no effect", got_rdata, first_id);

        // R8 and R3: erase address not halved
        run_txn(2'd3, 1'b0, 8'hD8, 25'h0AB_CDE0, 32'h0);
        chk(n_oe == 8 && n_cap == 0 && n_valid == 0, "R8 erase no data phase", 32'(n_cap), 32'h0);
        chk(header_ok(8'hD8, 6, 24'hAB_CDE0), "R3 erase address unhalved",
            {8'h0, out_lo[2], out_lo[3], out_lo[4], out_lo[5], out_lo[6], out_lo[7]}, 32'h00AB_CDE0);

        // R9: every misaligned pattern
        for (int m = 1; m < 4; m++) begin
            run_txn(2'd0, 1'b1, 8'h32, 25'h100 | 25'(m), 32'h1234_5678);
            chk(n_align == 1 && n_oe == 0 && n_busy == 0, "R9 misaligned rejected",
                32'(n_align), 32'd1);
            @(negedge clk);
            chk(!align_err && !busy, "R9 align_err single cycle", {31'h0, align_err}, 32'h0);
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule